// File: doc/BRIEF.md
# Multi-pulse transmit and sample-gate timing generator

This block drives the pulse trains of a pulse-induction front end. One free-running period counter, advancing once per 10 ns tick, serves as the time base for four transmit channels and eight receive sample-gate channels. Because both paths use the same counter, every sample gate stays locked to the transmit pulses. A strobe marks count zero of every period, so the acquisition logic downstream can align its frames to it.

Each channel holds a list of four pulses. Each pulse has a 16-bit start tick and a 16-bit end tick, both measured from the period start. A channel output is the OR of its pulses, so one channel can fire several times per period. A simple write port loads all timing into shadow storage. The shadow values move into the working set only when the period wraps, so a waveform never mixes old and new settings.

Top module: `pulse_timing_gen`

## Requirements
- R1: While enabled, the counter steps 0,1,...,P and then returns to 0, where P is the working period value, so one period lasts P+1 cycles. `frame_start` is high exactly in the cycles where the block is enabled and the count is 0. With P=0 it is high in every enabled cycle.
- R2: Transmit output `tx_out[c]` (c in 0..3) is high in a cycle exactly when the count satisfies start <= count < end for at least one of that channel's working pulses.
- R3: Sample gate `rx_gate[g]` (g in 0..7) follows the same rule as R2, using table channel 4+g and the same counter as the transmit outputs.
- R4: Each channel has four pulse slots, and its output is the OR of all four. A channel can therefore give several separate pulses in one period.
- R5: A pulse whose end is less than or equal to its start adds nothing to its channel's output.
- R6: Write map for `wr_addr`. If bit 7 is 1, the write loads the period and the low bits are ignored. If bit 7 is 0, bits 6:3 select the table channel (0-3 transmit, 4-11 receive), bits 2:1 select the pulse slot, and bit 0 selects start (0) or end (1). Writes to table channels 12-15 change nothing.
- R7: A write goes to shadow storage. Shadow storage is copied to the working set in the cycle the count is at P, so the new value first applies at the next count 0. A write made in that same wrap cycle waits one more period.
- R8: While `en` is 0, all outputs and `frame_start` stay low, the counter is held at 0, and the working set follows shadow storage. When `en` rises, the period starts at count 0 with the latest values.
- R9: After reset, all pulse times and the period are 0, so all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz tick clock |
| rst_n | input | 1 | asynchronous active-low reset |
| en | input | 1 | global run enable |
| wr_en | input | 1 | write strobe |
| wr_addr | input | 8 | write address, see R6 |
| wr_data | input | 16 | write data in ticks |
| tx_out | output | 4 | transmit pulse outputs |
| rx_gate | output | 8 | receive sample-gate outputs |
| frame_start | output | 1 | high in count-0 cycles |

## Verification
Two events can fall in the same cycle: a host write and the period wrap that copies shadow storage into the working set. The bench runs the counter until the count sits at the period value and issues a write right then. The expected waveforms come from a bench model in which that write reaches shadow storage only after the copy. The check therefore passes only if the new value appears a full period later. Random writes during a run hit this same collision by chance, and all 12 outputs are compared against the model in every cycle.

// File: rtl/pulse_timing_gen.sv
module pulse_timing_gen #(
  parameter int TX_CH  = 4,
  parameter int RX_CH  = 8,
  parameter int PULSES = 4,
  parameter int TW     = 16,
  parameter int AW     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [TW-1:0]    wr_data,
  output logic [TX_CH-1:0] tx_out,
  output logic [RX_CH-1:0] rx_gate,
  output logic             frame_start
);
  localparam int NCH = TX_CH + RX_CH;
  localparam int CW  = $clog2(NCH);
  localparam int PB  = $clog2(PULSES);
  localparam logic [TW-1:0] ONE = 1;

  logic [TW-1:0] sh_st [NCH][PULSES];
  logic [TW-1:0] sh_en [NCH][PULSES];
  logic [TW-1:0] ac_st [NCH][PULSES];
  logic [TW-1:0] ac_en [NCH][PULSES];
  logic [TW-1:0] per_s, per_a, cnt;
  logic [NCH-1:0] ch_on;

  wire          wrap = !en || (cnt == per_a);
  wire [CW-1:0] wch  = wr_addr[PB+CW:PB+1];
  wire [PB-1:0] wp   = wr_addr[PB:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int p = 0; p < PULSES; p++) begin
          sh_st[c][p] <= '0; sh_en[c][p] <= '0;
          ac_st[c][p] <= '0; ac_en[c][p] <= '0;
        end
      per_s <= '0;
      per_a <= '0;
      cnt   <= '0;
    end else begin
      if (wrap) begin
        ac_st <= sh_st;
        ac_en <= sh_en;
        per_a <= per_s;
      end
      if (wr_en) begin
        if (wr_addr[AW-1])
          per_s <= wr_data;
        else if (int'(wch) < NCH) begin
          if (wr_addr[0]) sh_en[wch][wp] <= wr_data;
          else            sh_st[wch][wp] <= wr_data;
        end
      end
      cnt <= wrap ? '0 : cnt + ONE;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [PULSES-1:0] hit;
    for (genvar p = 0; p < PULSES; p++) begin : g_p
      assign hit[p] = (cnt >= ac_st[c][p]) && (cnt < ac_en[c][p]);
    end
    assign ch_on[c] = en && |hit;
  end

  assign tx_out      = ch_on[TX_CH-1:0];
  assign rx_gate     = ch_on[NCH-1:TX_CH];
  assign frame_start = en && (cnt == '0);
endmodule

// File: rtl/pulse_timing_gen_chk.sv
module pulse_timing_gen_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          frame_start,
  input logic [TW-1:0] cnt,
  input logic [TW-1:0] per_a
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != per_a) |=> (cnt == $past(cnt) + 1'b1)); // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == per_a) |=> (cnt == '0)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_a); // R1
  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && per_a != '0 && en) |=> !frame_start); // R1
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R8
  AST_PERIOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != per_a) |=> $stable(per_a)); // R7
endmodule

bind pulse_timing_gen pulse_timing_gen_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .frame_start(frame_start),
  .cnt(cnt), .per_a(per_a)
);

// File: tb/tb_pulse_timing_gen.sv
module tb_pulse_timing_gen;
  logic clk = 0;
  always #10 clk = ~clk;

  logic        rst_n, en, wr_en;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic [3:0]  tx_out;
  logic [7:0]  rx_gate;
  logic        frame_start;

  pulse_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tx_out(tx_out), .rx_gate(rx_gate), .frame_start(frame_start)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag = "R9";

  logic [15:0] ms_st [12][4];
  logic [15:0] ms_en [12][4];
  logic [15:0] ma_st [12][4];
  logic [15:0] ma_en [12][4];
  logic [15:0] m_psh, m_pac, m_cnt;

  function automatic logic [11:0] exp_ch();
    logic [11:0] r = '0;
    for (int c = 0; c < 12; c++)
      for (int p = 0; p < 4; p++)
        if (m_cnt >= ma_st[c][p] && m_cnt < ma_en[c][p]) r[c] = en;
    return r;
  endfunction

  function automatic logic [7:0] adr(int ch, int p, bit e);
    return {1'b0, 4'(ch), 2'(p), e};
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 12; c++)
      for (int p = 0; p < 4; p++) begin
        ms_st[c][p] = 0; ms_en[c][p] = 0; ma_st[c][p] = 0; ma_en[c][p] = 0;
      end
    m_psh = 0; m_pac = 0; m_cnt = 0;
  endtask

  task automatic model_step();
    logic wrap;
    logic [15:0] nxt;
    int ch, p;
    wrap = !en || (m_cnt == m_pac);
    nxt  = wrap ? 16'd0 : m_cnt + 16'd1;
    if (wrap) begin ma_st = ms_st; ma_en = ms_en; m_pac = m_psh; end
    if (wr_en) begin
      if (wr_addr[7]) m_psh = wr_data;
      else begin
        ch = int'(wr_addr[6:3]); p = int'(wr_addr[2:1]);
        if (ch < 12) begin
          if (wr_addr[0]) ms_en[ch][p] = wr_data;
          else            ms_st[ch][p] = wr_data;
        end
      end
    end
    m_cnt = nxt;
  endtask

  task automatic cmp();
    logic [11:0] e;
    logic efs;
    e = exp_ch();
    efs = en && (m_cnt == 0);
    n_chk++;
    if (tx_out !== e[3:0] || rx_gate !== e[11:4] || frame_start !== efs) begin
      n_bad++;
      $display("FAIL %s: tx=%h rx=%h fs=%b expected tx=%h rx=%h fs=%b",
               tag, tx_out, rx_gate, frame_start, e[3:0], e[11:4], efs);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic pulse(int ch, int p, int s, int e);
    wr(adr(ch, p, 0), 16'(s));
    wr(adr(ch, p, 1), 16'(e));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; en = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    model_reset();
    tag = "R9";
    @(negedge clk); cmp();
    @(negedge clk); cmp();
    rst_n = 1;
    en = 1;
    run(5);

    tag = "R2 R4";
    en = 0;
    wr(8'h80, 16'd19);
    pulse(0, 0, 2, 5);
    pulse(0, 1, 8, 10);
    pulse(1, 0, 0, 3);
    pulse(3, 3, 15, 25);
    en = 1;
    run(45);

    tag = "R3";
    pulse(4, 0, 1, 4);
    pulse(11, 2, 6, 12);
    pulse(11, 3, 14, 16);
    run(45);

    tag = "R5";
    pulse(2, 0, 7, 7);
    pulse(2, 1, 9, 4);
    pulse(2, 2, 3, 4);
    run(45);

    tag = "R6";
    pulse(13, 0, 0, 19);
    pulse(15, 3, 0, 19);
    wr(8'hFF, 16'd9);
    run(45);

    tag = "R7";
    while (m_cnt != 5) tick();
    pulse(0, 0, 0, 12);
    run(10);
    while (m_cnt != m_pac) tick();
    wr(adr(1, 0, 1), 16'd8);
    run(30);

    tag = "R8";
    en = 0;
    run(6);
    pulse(5, 0, 0, 2);
    wr(8'h80, 16'd11);
    run(4);
    en = 1;
    run(30);

    tag = "R1";
    wr(8'h80, 16'd0);
    run(12);
    wr(8'h80, 16'd3);
    run(12);

    tag = "R2 R3";
    wr(8'h80, 16'd25);
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 199) == 0) en = ~en;
      if ($urandom_range(0, 5) == 0) begin
        wr_en = 1;
        if ($urandom_range(0, 19) == 0) begin
          wr_addr = 8'h80; wr_data = 16'($urandom_range(0, 40));
        end else begin
          wr_addr = adr($urandom_range(0, 13), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
          wr_data = 16'($urandom_range(0, 45));
        end
      end
      tick();
      wr_en = 0;
    end
    finish_run();
  end
endmodule